// File: doc/BRIEF.md
# Dual-Window I²t Overcurrent Protector

This block watches the load current of a hot-swap or electronic-fuse power switch and decides when the switch must act. On every sample tick it takes an unsigned current code, squares it, and feeds the square into three energy checks that run side by side. The first is a fast window for hard shorts: it integrates I² only while the current sits above a fast threshold, and it opens the gate at once when that energy passes its limit. The second is a soft window for inrush and soft-start: it integrates I² while the switch reports that it is in current limit. When this window runs out of energy the block asks for foldback or timeout, not a hard trip. The third is a rolling budget that sums the squares of the last few samples.

Every declared event produces one log record. The record holds the window type, the timestamp of the sample, the peak current, the duration in samples and a reason word. Two saturating counters tally fast and soft events. A clear strobe releases the latched trip and the rolling fault. Thresholds, limits, the debounce length and the rolling length are static configuration inputs. Sensing, gate drive and log storage sit outside the block.

Top module: `dual_window_i2t`

## Requirements
- R1: Fast window: on each sample where `cur_code > fast_thresh`, the square of `cur_code` (24-bit) is added to a 40-bit saturating fast accumulator. Any sample at or below the threshold zeroes the fast accumulator, its duration and its peak.
- R2: A fast event is declared on the sample where the fast accumulator exceeds `fast_limit` and has done so on `debounce` earlier consecutive samples. With `debounce` = 0 this is the first such sample. `trip` rises one clock after that sample's tick and stays high until `clr`.
- R3: Soft window: while `in_limit` is 1 on a sample, the square is added to a saturating soft accumulator. A sample with `in_limit` = 0 zeroes it. A soft event uses the same debounce rule against `soft_limit` and sets `foldback_req`. `foldback_req` holds until a sample with `in_limit` = 0, or until `clr`. At most one soft event occurs per limit episode.
- R4: Rolling budget: the block keeps the sum of the squares of the last `roll_len` samples (1..16), dropping the oldest square as each new one enters. The first sample whose sum exceeds `roll_limit` sets `roll_fault`, which stays latched until `clr`. The rolling budget has no debounce.
- R5: Priority is fast over soft over rolling within one sample. A lower-priority event that coincides with a higher one is not logged or counted. A suppressed soft event does not raise `foldback_req` and does not fire again in that episode. A suppressed rolling event still latches `roll_fault`.
- R6: Log record: `log_valid` is high for exactly the clock after an event sample. `log_win` is 1 for fast, 2 for soft and 3 for rolling. `log_ts` is `timestamp` at the event sample. For fast and soft events, `log_peak` is the largest code in the episode and `log_dur` is the number of samples in the episode, counting the event sample. For rolling events they are the current code and `roll_len`. `log_reason` bit0, bit1 and bit2 show whether the fast, soft and rolling limits were exceeded on that sample.
- R7: `fast_cnt` and `soft_cnt` count logged fast and soft events. They saturate at all ones and are not affected by `clr`.
- R8: `clr` clears `trip`, `foldback_req` and `roll_fault`, all three accumulators, the rolling history and the debounce state. A sample in the same cycle as `clr` is ignored.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Clear latched faults and window state |
| sample_en | input | 1 | Sample tick: current code is valid |
| cur_code | input | 12 | Unsigned load-current code |
| in_limit | input | 1 | Switch is regulating current (soft-start) |
| timestamp | input | 32 | Free-running time stamp |
| fast_thresh | input | 12 | Current above which the fast window integrates |
| fast_limit | input | 40 | Fast window energy limit |
| soft_limit | input | 40 | Soft window energy limit |
| roll_limit | input | 40 | Rolling budget energy limit |
| debounce | input | 4 | Extra qualifying samples before an event |
| roll_len | input | 5 | Rolling window length in samples |
| trip | output | 1 | Latched gate-off request |
| foldback_req | output | 1 | Foldback or timeout request |
| roll_fault | output | 1 | Latched rolling-budget fault |
| fast_cnt | output | 8 | Fast event count |
| soft_cnt | output | 8 | Soft event count |
| log_valid | output | 1 | Log record strobe |
| log_win | output | 2 | Window type of the record |
| log_ts | output | 32 | Time stamp of the record |
| log_peak | output | 12 | Peak current of the record |
| log_dur | output | 16 | Duration of the record in samples |
| log_reason | output | 3 | Limits exceeded on the event sample |

## Verification
A wrong accumulator or debounce count shows up as a trip or a foldback request that arrives one or more samples early or late. The bench looks at the sample where the limit is first crossed and at the one after it, so such an error is seen within one sample tick. A rolling sum that fails to drop its oldest square does not stay hidden either. In a sequence whose short-window sum stays under the limit while its total history crosses it, `roll_fault` rises on the first sample where the two sums differ. Errors in priority or per-episode state appear on the very next `log_valid` strobe, as a wrong window code, a wrong reason word or a wrong counter value.

// File: rtl/dual_window_i2t.sv
module dual_window_i2t #(
  parameter int CUR_W = 12,
  parameter int ACC_W = 40,
  parameter int TS_W  = 32,
  parameter int DUR_W = 16,
  parameter int CNT_W = 8,
  parameter int DEB_W = 4,
  parameter int DEPTH = 16,
  localparam int SQ_W  = 2 * CUR_W,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample_en,
  input  logic [CUR_W-1:0] cur_code,
  input  logic             in_limit,
  input  logic [TS_W-1:0]  timestamp,
  input  logic [CUR_W-1:0] fast_thresh,
  input  logic [ACC_W-1:0] fast_limit,
  input  logic [ACC_W-1:0] soft_limit,
  input  logic [ACC_W-1:0] roll_limit,
  input  logic [DEB_W-1:0] debounce,
  input  logic [LEN_W-1:0] roll_len,
  output logic             trip,
  output logic             foldback_req,
  output logic             roll_fault,
  output logic [CNT_W-1:0] fast_cnt,
  output logic [CNT_W-1:0] soft_cnt,
  output logic             log_valid,
  output logic [1:0]       log_win,
  output logic [TS_W-1:0]  log_ts,
  output logic [CUR_W-1:0] log_peak,
  output logic [DUR_W-1:0] log_dur,
  output logic [2:0]       log_reason
);
  localparam logic [1:0] WIN_FAST = 2'd1;
  localparam logic [1:0] WIN_SOFT = 2'd2;
  localparam logic [1:0] WIN_ROLL = 2'd3;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  logic [SQ_W-1:0]  sq;
  logic [ACC_W-1:0] f_acc, s_acc, r_sum;
  logic [DEB_W-1:0] f_deb, s_deb;
  logic [DUR_W-1:0] f_dur, s_dur;
  logic [CUR_W-1:0] f_peak, s_peak;
  logic             s_done;
  logic [SQ_W-1:0]  rbuf [DEPTH];
  logic [PTR_W-1:0] ptr;

  assign sq = SQ_W'(cur_code) * SQ_W'(cur_code);

  // fast window
  logic             f_hot, f_over, f_fire;
  logic [ACC_W-1:0] f_acc_n;
  logic [DUR_W-1:0] f_dur_n;
  logic [CUR_W-1:0] f_peak_n;
  assign f_hot    = cur_code > fast_thresh;
  assign f_acc_n  = f_hot ? sat_add(f_acc, ACC_W'(sq)) : '0;
  assign f_dur_n  = !f_hot ? '0 : (f_dur == '1 ? f_dur : f_dur + 1'b1);
  assign f_peak_n = !f_hot ? '0 : (cur_code > f_peak ? cur_code : f_peak);
  assign f_over   = f_hot && (f_acc_n > fast_limit);
  assign f_fire   = sample_en && f_over && !trip && (f_deb == debounce);

  // soft window
  logic             s_over, s_qual, s_fire;
  logic [ACC_W-1:0] s_acc_n;
  logic [DUR_W-1:0] s_dur_n;
  logic [CUR_W-1:0] s_peak_n;
  assign s_acc_n  = in_limit ? sat_add(s_acc, ACC_W'(sq)) : '0;
  assign s_dur_n  = !in_limit ? '0 : (s_dur == '1 ? s_dur : s_dur + 1'b1);
  assign s_peak_n = !in_limit ? '0 : (cur_code > s_peak ? cur_code : s_peak);
  assign s_over   = in_limit && (s_acc_n > soft_limit);
  assign s_qual   = sample_en && s_over && !s_done && (s_deb == debounce);
  assign s_fire   = s_qual && !f_fire;

  // rolling budget
  logic             r_over, r_qual, r_fire;
  logic [ACC_W-1:0] r_sum_n;
  logic [LEN_W:0]   ptr_inc;
  logic [PTR_W-1:0] ptr_n;
  assign r_sum_n = r_sum + ACC_W'(sq) - ACC_W'(rbuf[ptr]);
  assign r_over  = r_sum_n > roll_limit;
  assign r_qual  = sample_en && r_over && !roll_fault;
  assign r_fire  = r_qual && !f_fire && !s_fire;
  assign ptr_inc = (LEN_W+1)'(ptr) + 1'b1;
  assign ptr_n   = (ptr_inc >= (LEN_W+1)'(roll_len) || ptr == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(ptr_inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {trip, foldback_req, roll_fault, s_done, log_valid} <= '0;
      {f_acc, s_acc, r_sum, f_deb, s_deb, f_dur, s_dur, f_peak, s_peak, ptr} <= '0;
      {fast_cnt, soft_cnt, log_win, log_ts, log_peak, log_dur, log_reason} <= '0;
      for (int i = 0; i < DEPTH; i++) rbuf[i] <= '0;
    end else if (clr) begin
      {trip, foldback_req, roll_fault, s_done, log_valid} <= '0;
      {f_acc, s_acc, r_sum, f_deb, s_deb, f_dur, s_dur, f_peak, s_peak, ptr} <= '0;
      for (int i = 0; i < DEPTH; i++) rbuf[i] <= '0;
    end else begin
      log_valid <= sample_en && (f_fire || s_fire || r_fire);
      if (sample_en) begin
        f_acc  <= f_acc_n;
        f_dur  <= f_dur_n;
        f_peak <= f_peak_n;
        f_deb  <= !f_over ? '0 : (f_deb == debounce ? f_deb : f_deb + 1'b1);
        s_acc  <= s_acc_n;
        s_dur  <= s_dur_n;
        s_peak <= s_peak_n;
        s_deb  <= !s_over ? '0 : (s_deb == debounce ? s_deb : s_deb + 1'b1);
        s_done <= in_limit && (s_done || s_qual);
        r_sum  <= r_sum_n;
        rbuf[ptr] <= sq;
        ptr    <= ptr_n;
        if (f_fire) trip <= 1'b1;
        if (r_qual) roll_fault <= 1'b1;
        if (!in_limit) foldback_req <= 1'b0;
        else if (s_fire) foldback_req <= 1'b1;
        if (f_fire && fast_cnt != '1) fast_cnt <= fast_cnt + 1'b1;
        if (s_fire && soft_cnt != '1) soft_cnt <= soft_cnt + 1'b1;
        if (f_fire || s_fire || r_fire) begin
          log_ts     <= timestamp;
          log_reason <= {r_over, s_over, f_over};
          log_win    <= f_fire ? WIN_FAST : (s_fire ? WIN_SOFT : WIN_ROLL);
          log_peak   <= f_fire ? f_peak_n : (s_fire ? s_peak_n : cur_code);
          log_dur    <= f_fire ? f_dur_n : (s_fire ? s_dur_n : DUR_W'(roll_len));
        end
      end
    end
  end

  p_trip_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip && !clr |=> trip);
  p_trip_logged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> log_valid && log_win == WIN_FAST);
  p_fb_needs_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(foldback_req) |-> $past(in_limit) && $past(sample_en));
  p_roll_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    roll_fault && !clr |=> roll_fault);
  p_log_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> $past(sample_en) && !$past(clr));
  p_fast_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fast_cnt == '1 |=> fast_cnt == '1);
  p_soft_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_cnt == '1 |=> soft_cnt == '1);
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !trip && !roll_fault && !foldback_req && !log_valid);
endmodule

// File: tb/test_dual_window_i2t.sv
module test_dual_window_i2t;
  logic        clk = 0, rst_n = 0, clr = 0, sample_en = 0, in_limit = 0;
  logic [11:0] cur_code = 0, fast_thresh = 12'd1000;
  logic [31:0] timestamp = 32'd100;
  logic [39:0] fast_limit = 40'd3000000, soft_limit = 40'd100000, roll_limit = '1;
  logic [3:0]  debounce = 4'd1;
  logic [4:0]  roll_len = 5'd4;
  logic        trip, foldback_req, roll_fault, log_valid;
  logic [7:0]  fast_cnt, soft_cnt;
  logic [1:0]  log_win;
  logic [31:0] log_ts, exp_ts;
  logic [11:0] log_peak;
  logic [15:0] log_dur;
  logic [2:0]  log_reason;
  int checks = 0, errors = 0;
  bit done = 0;

  dual_window_i2t i_dual_window_i2t (.*);

  always #5 clk = ~clk;
  always @(negedge clk) timestamp <= timestamp + 1;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(input int c, input bit lim);
    @(negedge clk); #1;
    cur_code = 12'(c); in_limit = lim; sample_en = 1; exp_ts = timestamp;
    @(negedge clk); #1;
    sample_en = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); #1; clr = 1;
    @(negedge clk); #1; clr = 0;
  endtask

  localparam int N = 12;
  localparam int VC [N] = '{500, 200, 200, 200, 200, 200, 200, 1100, 1100, 1100, 1100, 0};
  localparam int VL [N] = '{0, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0};
  localparam int VT [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int VF [N] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0};
  localparam int VV [N] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0};
  localparam int VW [N] = '{0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 1, 0};
  localparam int VP [N] = '{0, 0, 0, 0, 200, 0, 0, 0, 0, 0, 1100, 0};
  localparam int VD [N] = '{0, 0, 0, 0, 4, 0, 0, 0, 0, 0, 4, 0};
  localparam int VR [N] = '{0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 1, 0};

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 trip", trip, 0);
    check("R9 foldback", foldback_req, 0);
    check("R9 roll_fault", roll_fault, 0);
    check("R9 log_valid", log_valid, 0);
    check("R9 counters", fast_cnt + soft_cnt, 0);
    rst_n = 1;

    // R1 R2 R3 R6 table walk
    for (int k = 0; k < N; k++) begin
      sample(VC[k], VL[k] != 0);
      check("R2 trip", trip, VT[k]);
      check("R3 foldback", foldback_req, VF[k]);
      check("R6 log_valid", log_valid, VV[k]);
      if (VV[k] != 0) begin
        check("R6 log_win", log_win, VW[k]);
        check("R6 log_peak", log_peak, VP[k]);
        check("R1 log_dur", log_dur, VD[k]);
        check("R6 log_reason", log_reason, VR[k]);
        check("R6 log_ts", log_ts, exp_ts);
      end
    end
    check("R7 fast_cnt", fast_cnt, 1);
    check("R7 soft_cnt", soft_cnt, 1);

    pulse_clr();
    check("R8 trip cleared", trip, 0);
    check("R7 counters kept", fast_cnt, 1);

    // R2 debounce zero
    debounce = 0;
    sample(1100, 0); sample(1100, 0);
    check("R2 no early trip", trip, 0);
    sample(1100, 0);
    check("R2 trip deb0", trip, 1);
    pulse_clr();

    // R5 fast and soft on one sample
    debounce = 1; soft_limit = 40'd3000000;
    sample(1100, 1); sample(1100, 1); sample(1100, 1);
    check("R5 none yet", log_valid, 0);
    sample(1100, 1);
    check("R5 win fast", log_win, 1);
    check("R5 reason", log_reason, 3);
    check("R5 no foldback", foldback_req, 0);
    check("R5 fast_cnt", fast_cnt, 3);
    check("R5 soft_cnt", soft_cnt, 1);
    sample(1100, 1);
    check("R5 soft suppressed", log_valid, 0);
    check("R5 foldback still low", foldback_req, 0);
    pulse_clr();

    // R4 rolling budget
    soft_limit = 40'd100000; roll_limit = 40'd3000000;
    sample(900, 0); sample(900, 0); sample(900, 0);
    check("R4 under budget", roll_fault, 0);
    sample(900, 0);
    check("R4 roll_fault", roll_fault, 1);
    check("R4 log_win", log_win, 3);
    check("R4 log_peak", log_peak, 900);
    check("R4 log_dur", log_dur, 4);
    check("R4 log_reason", log_reason, 4);
    sample(0, 0);
    check("R4 latched", roll_fault, 1);
    pulse_clr();
    check("R8 roll cleared", roll_fault, 0);

    // R4 sliding: oldest square must drop out
    sample(900, 0); sample(900, 0); sample(900, 0); sample(0, 0);
    sample(900, 0); sample(900, 0); sample(900, 0);
    check("R4 slide no fault", roll_fault, 0);
    sample(900, 0);
    check("R4 slide fault", roll_fault, 1);

    // R8 sample during clr ignored
    pulse_clr();
    @(negedge clk); #1;
    clr = 1; sample_en = 1; cur_code = 12'd4000; in_limit = 1; debounce = 0;
    @(negedge clk); #1;
    clr = 0; sample_en = 0;
    check("R8 ignored sample", log_valid, 0);
    check("R8 ignored trip", trip, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule